// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host indirect access to a network controller's local packet memory through a single data port. The host loads a 16-bit transfer address and a 16-bit byte count, one byte at a time, through a small register write port. It then reads or writes the data port repeatedly. Each access touches memory at the current transfer address. The address then advances by the transfer width and the count drops by the same amount. When the count runs out, a sticky completion flag is raised.

Transfers are either one byte or one little-endian 16-bit word per access, chosen by a configuration bit. The address wraps from the receive ring's stop page back to its start page, so a host can walk across the end of the ring without reprogramming. Only two address windows are backed by storage. Reads anywhere else return all ones, and writes anywhere else are dropped. The storage is a synchronous byte-wide RAM. A byte access completes in two cycles and a word access in three, and a one-cycle ready pulse marks completion.

Top module: `rdma_port`

## Requirements
- R1: After reset the transfer address, remaining count, completion flag and ready output are all zero.
- R2: Register write select codes: 0 command, 1 address bits 7:0, 2 address bits 15:8, 3 count bits 7:0, 4 count bits 15:8, 5 ring start page, 6 ring stop page, 7 configuration (bit 0 = word mode), 8 status clear. Address and count bytes load independently and appear on `cur_addr_o` and `remain_o`.
- R3: In byte mode a port write stores `port_wdata_i[7:0]` at the current address, and a port read returns `{8'h00, byte}`. Either access adds 1 to the address.
- R4: In word mode the access uses the current address with bit 0 cleared. The low data byte is at the even address and the high byte at the odd address. The address register then grows by 2 from its unaligned value.
- R5: If the advanced address equals stop page times 256, the address becomes start page times 256 instead.
- R6: After each access, if the remaining count is at most the step (1 or 2), it becomes zero and the completion flag is set. Otherwise the count is reduced by the step. This also applies to reads issued at a count of zero.
- R7: A port write while the remaining count is zero changes no memory, no address and no count. It still gives a ready pulse one cycle after the strobe.
- R8: A command write with bit 0 (stop) clear, bit 3 (read) or bit 4 (write) set, and a count of zero sets the completion flag on that clock edge. Any other command leaves the flag alone.
- R9: Only addresses below LO_WIN (32) and from HI_BASE (16384) up to HI_BASE+HI_SIZE-1 are backed. Bytes read elsewhere are 8'hFF, and writes elsewhere alter nothing.
- R10: Writing select 8 with data bit 6 set clears the completion flag. A flag set in the same cycle wins.
- R11: Counted from the clock edge that samples the strobe, `port_rdy_o` is high during the 2nd cycle for a byte access and the 3rd cycle for a word access. Read data is valid while ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 4 | Register select code |
| reg_wdata_i | input | 8 | Register write data |
| port_rd_i | input | 1 | Data port read strobe |
| port_wr_i | input | 1 | Data port write strobe |
| port_wdata_i | input | 16 | Data port write data |
| port_rdata_o | output | 16 | Data port read data, valid with ready |
| port_rdy_o | output | 1 | One-cycle access completion pulse |
| dma_done_o | output | 1 | Sticky transfer complete flag |
| cur_addr_o | output | 16 | Current transfer address |
| remain_o | output | 16 | Remaining byte count |

## Verification
The bench goes after the wrap at the ring's stop page in both widths, including a word step that lands exactly on the stop address. A design that compared with greater-or-equal, or used the aligned address, would walk off the ring or skip a page. It reads words at odd addresses and reads bytes back from word writes, which exposes a design that fails to clear the low address bit or swaps the byte order. It probes the last backed byte and the first unbacked byte on both sides of each window. There a broken decoder would alias writes into real storage or return stale data instead of all ones. It also checks the zero-count cases: ignored writes, the immediate completion from a command, a count of one in word mode, and the stop bit suppressing completion. A design that counted down past zero or kept writing would show a wrapped count or corrupted memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_FIN} seq_st_e;

  localparam logic [3:0] SEL_CMD     = 4'd0;
  localparam logic [3:0] SEL_ADDR_LO = 4'd1;
  localparam logic [3:0] SEL_ADDR_HI = 4'd2;
  localparam logic [3:0] SEL_CNT_LO  = 4'd3;
  localparam logic [3:0] SEL_CNT_HI  = 4'd4;
  localparam logic [3:0] SEL_RING_LO = 4'd5;
  localparam logic [3:0] SEL_RING_HI = 4'd6;
  localparam logic [3:0] SEL_CFG     = 4'd7;
  localparam logic [3:0] SEL_CLR     = 4'd8;

  localparam int CMD_STOP_BIT = 0;
  localparam int CMD_RD_BIT   = 3;
  localparam int CMD_WR_BIT   = 4;
  localparam int DONE_BIT     = 6;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input int unsigned lo_win,
                                     input int unsigned hi_base,
                                     input int unsigned hi_size);
    int unsigned u;
    u = 32'(a);
    return (u < lo_win) || (u >= hi_base && u < hi_base + hi_size);
  endfunction
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] remain_o,
  output logic              word_mode_o,
  output logic              done_o
);
  localparam int PAGE_SHIFT = 8;

  logic [7:0]        start_pg_q, stop_pg_q;
  logic [ADDR_W-1:0] ring_start, ring_stop, step, addr_inc, addr_nxt;
  logic              zero_cmd;

  assign ring_start = ADDR_W'(start_pg_q) << PAGE_SHIFT;
  assign ring_stop  = ADDR_W'(stop_pg_q) << PAGE_SHIFT;
  assign step       = word_mode_o ? ADDR_W'(2) : ADDR_W'(1);
  assign addr_inc   = cur_addr_o + step;
  assign addr_nxt   = (addr_inc == ring_stop) ? ring_start : addr_inc;
  assign zero_cmd   = reg_we_i && (reg_sel_i == SEL_CMD) && !reg_wdata_i[CMD_STOP_BIT]
                      && (reg_wdata_i[CMD_RD_BIT] || reg_wdata_i[CMD_WR_BIT])
                      && (remain_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_o  <= '0;
      remain_o    <= '0;
      start_pg_q  <= '0;
      stop_pg_q   <= '0;
      word_mode_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_sel_i)
          SEL_ADDR_LO: cur_addr_o[7:0]  <= reg_wdata_i;
          SEL_ADDR_HI: cur_addr_o[15:8] <= reg_wdata_i;
          SEL_CNT_LO:  remain_o[7:0]    <= reg_wdata_i;
          SEL_CNT_HI:  remain_o[15:8]   <= reg_wdata_i;
          SEL_RING_LO: start_pg_q       <= reg_wdata_i;
          SEL_RING_HI: stop_pg_q        <= reg_wdata_i;
          SEL_CFG:     word_mode_o      <= reg_wdata_i[0];
          SEL_CLR:     if (reg_wdata_i[DONE_BIT]) done_o <= 1'b0;
          default: ;
        endcase
      end
      if (zero_cmd) done_o <= 1'b1;
      // access update wins over a concurrent host write
      if (adv_i) begin
        cur_addr_o <= addr_nxt;
        if (remain_o <= step) begin
          remain_o <= '0;
          done_o   <= 1'b1;
        end else begin
          remain_o <= remain_o - step;
        end
      end
    end
  end

  // R6
  remain_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_o > $past(remain_o)) |-> $past(reg_we_i));
  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(adv_i) || $past(zero_cmd)));
  // R5
  ring_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && addr_inc == ring_stop) |=> (cur_addr_o == $past(ring_start)));
endmodule

// File: rtl/rdma_mem.sv
module rdma_mem
  import rdma_pkg::*;
#(
  parameter int unsigned LO_WIN  = 32,
  parameter int unsigned HI_BASE = 16384,
  parameter int unsigned HI_SIZE = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        q_o,
  output logic              hit_o
);
  localparam int unsigned DEPTH = LO_WIN + HI_SIZE;
  localparam int unsigned IW    = $clog2(DEPTH);

  logic [7:0]    ram [DEPTH];
  logic          hit;
  logic [IW-1:0] idx;
  int unsigned   a;

  always_comb begin
    a   = 32'(addr_i);
    hit = in_window(addr_i, LO_WIN, HI_BASE, HI_SIZE);
    if (!hit)            idx = '0;
    else if (a < LO_WIN) idx = IW'(a);
    else                 idx = IW'(a - HI_BASE + LO_WIN);
  end

  always_ff @(posedge clk_i) begin
    if (we_i && hit) ram[idx] <= wdata_i;
    q_o <= ram[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= hit;
  end
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
  import rdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] remain_i,
  input  logic              word_mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_q_i,
  input  logic              mem_hit_i,
  output logic              adv_o,
  output logic              rdy_o,
  output logic [15:0]       rdata_o
);
  seq_st_e           st_q;
  logic              is_wr_q, skip_q, wm_q;
  logic [ADDR_W-1:0] base_q;
  logic [15:0]       wd_q;
  logic [7:0]        lo_q, byte_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      is_wr_q <= 1'b0;
      skip_q  <= 1'b0;
      wm_q    <= 1'b0;
      base_q  <= '0;
      wd_q    <= '0;
      lo_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (wr_i || rd_i) begin
            is_wr_q <= wr_i;
            wm_q    <= word_mode_i;
            wd_q    <= wdata_i;
            base_q  <= word_mode_i ? {cur_addr_i[ADDR_W-1:1], 1'b0} : cur_addr_i;
            if (wr_i && remain_i == '0) begin
              skip_q <= 1'b1;
              st_q   <= ST_FIN;
            end else begin
              skip_q <= 1'b0;
              st_q   <= ST_LO;
            end
          end
        end
        ST_LO: st_q <= wm_q ? ST_HI : ST_FIN;
        ST_HI: begin
          lo_q <= mem_hit_i ? mem_q_i : 8'hFF;
          st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = (st_q == ST_HI) ? (base_q | ADDR_W'(1)) : base_q;
  assign mem_we_o    = is_wr_q && (st_q == ST_LO || st_q == ST_HI);
  assign mem_wdata_o = (st_q == ST_HI) ? wd_q[15:8] : wd_q[7:0];
  assign adv_o       = (st_q == ST_FIN) && !skip_q;
  assign rdy_o       = (st_q == ST_FIN);
  assign byte_now    = mem_hit_i ? mem_q_i : 8'hFF;
  assign rdata_o     = (rdy_o && !is_wr_q) ? (wm_q ? {byte_now, lo_q} : {8'h00, byte_now})
                                           : 16'h0000;

  // R11
  rdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  // R7
  no_write_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (remain_i != '0));
  // R4
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO && wm_q) |-> !mem_addr_o[0]);
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int unsigned LO_WIN  = 32,
  parameter int unsigned HI_BASE = 16384,
  parameter int unsigned HI_SIZE = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        port_rd_i,
  input  logic        port_wr_i,
  input  logic [15:0] port_wdata_i,
  output logic [15:0] port_rdata_o,
  output logic        port_rdy_o,
  output logic        dma_done_o,
  output logic [15:0] cur_addr_o,
  output logic [15:0] remain_o
);
  logic              adv, word_mode, mem_we, mem_hit;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_q;

  rdma_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .adv_i(adv), .cur_addr_o, .remain_o,
    .word_mode_o(word_mode), .done_o(dma_done_o)
  );

  rdma_seq u_seq (
    .clk_i, .rst_ni, .rd_i(port_rd_i), .wr_i(port_wr_i), .wdata_i(port_wdata_i),
    .cur_addr_i(cur_addr_o), .remain_i(remain_o), .word_mode_i(word_mode),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_q_i(mem_q), .mem_hit_i(mem_hit),
    .adv_o(adv), .rdy_o(port_rdy_o), .rdata_o(port_rdata_o)
  );

  rdma_mem #(.LO_WIN(LO_WIN), .HI_BASE(HI_BASE), .HI_SIZE(HI_SIZE)) u_mem (
    .clk_i, .rst_ni, .addr_i(mem_addr), .we_i(mem_we), .wdata_i(mem_wdata),
    .q_o(mem_q), .hit_o(mem_hit)
  );
endmodule

// File: tb/sim_rdma_port.sv
`timescale 1ns/1ps
module sim_rdma_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, port_rd = 1'b0, port_wr = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] port_wdata = '0;
  logic [15:0] port_rdata, cur_addr, remain;
  logic        port_rdy, dma_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rdma_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .port_rd_i(port_rd), .port_wr_i(port_wr),
    .port_wdata_i(port_wdata), .port_rdata_o(port_rdata), .port_rdy_o(port_rdy),
    .dma_done_o(dma_done), .cur_addr_o(cur_addr), .remain_o(remain)
  );

  function automatic logic [7:0] bpat(int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [15:0] wpat(int i);
    return 16'(i * 16'h0102 + 16'h0F01);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_addr(logic [15:0] a);
    wr_reg(4'd1, a[7:0]); wr_reg(4'd2, a[15:8]);
  endtask
  task automatic set_cnt(logic [15:0] c);
    wr_reg(4'd3, c[7:0]); wr_reg(4'd4, c[15:8]);
  endtask
  task automatic clr_done();
    wr_reg(4'd8, 8'h40);
  endtask

  task automatic acc(bit w, logic [15:0] d, output logic [15:0] rd, output int lat);
    @(negedge clk);
    port_wr = w; port_rd = !w; port_wdata = d;
    @(posedge clk);
    @(negedge clk);
    port_wr = 1'b0; port_rd = 1'b0;
    lat = 1;
    while (!port_rdy && lat < 10) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    rd = port_rdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", cur_addr, 0); chk("R1 cnt", remain, 0);
    chk("R1 done", dma_done, 0); chk("R1 rdy", port_rdy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register loads
    set_addr(16'h1234); set_cnt(16'hABCD);
    chk("R2 addr", cur_addr, 16'h1234); chk("R2 cnt", remain, 16'hABCD);

    // R3 byte sweep over whole low window
    set_addr(16'h0000); set_cnt(16'd32);
    for (int i = 0; i < 32; i++) begin
      acc(1, {8'hA5, bpat(i)}, rd, lat);
      chk("R11 byte latency", lat, 2);
      chk("R3 addr step", cur_addr, i + 1);
      chk("R6 cnt step", remain, 31 - i);
    end
    chk("R6 done at end", dma_done, 1);
    clr_done();
    chk("R10 clear", dma_done, 0);
    set_addr(16'h0000); set_cnt(16'd32);
    for (int i = 0; i < 32; i++) begin
      acc(0, 0, rd, lat);
      chk("R3 byte read", rd, {8'h00, bpat(i)});
    end

    // R4 word writes, byte readback for order
    wr_reg(4'd7, 8'h01);
    set_addr(16'h4000); set_cnt(16'd64);
    for (int i = 0; i < 32; i++) begin
      acc(1, wpat(i), rd, lat);
      chk("R11 word latency", lat, 3);
      chk("R4 addr step", cur_addr, 16'h4000 + 2 * (i + 1));
    end
    chk("R6 word done", dma_done, 1);
    wr_reg(4'd7, 8'h00);
    set_addr(16'h4000); set_cnt(16'd64);
    for (int j = 0; j < 64; j++) begin
      logic [15:0] w;
      w = wpat(j / 2);
      acc(0, 0, rd, lat);
      chk("R4 little endian", rd, {8'h00, (j % 2 == 0) ? w[7:0] : w[15:8]});
    end
    wr_reg(4'd7, 8'h01);
    set_addr(16'h4000); set_cnt(16'd64);
    for (int i = 0; i < 32; i++) begin
      acc(0, 0, rd, lat);
      chk("R4 word read", rd, wpat(i));
    end
    // R4 odd address word read
    clr_done();
    set_addr(16'h4001); set_cnt(16'd2);
    acc(0, 0, rd, lat);
    chk("R4 odd read data", rd, wpat(0));
    chk("R4 odd addr", cur_addr, 16'h4003);
    chk("R6 cnt zero", remain, 0); chk("R6 done", dma_done, 1);

    // R5 ring wrap
    wr_reg(4'd5, 8'h40); wr_reg(4'd6, 8'h41);
    wr_reg(4'd7, 8'h00);
    set_addr(16'h40FF); set_cnt(16'd2);
    acc(1, 16'h005A, rd, lat);
    chk("R5 byte wrap", cur_addr, 16'h4000); chk("R5 cnt", remain, 1);
    acc(0, 0, rd, lat);
    chk("R5 read after wrap", rd, {8'h00, wpat(0) & 16'h00FF});
    wr_reg(4'd7, 8'h01);
    set_addr(16'h40FE); set_cnt(16'd4);
    acc(1, 16'h1357, rd, lat);
    chk("R5 word wrap", cur_addr, 16'h4000);
    wr_reg(4'd5, 8'h00); wr_reg(4'd6, 8'h00);

    // R7 ignored write at zero count
    clr_done();
    wr_reg(4'd7, 8'h00);
    set_addr(16'h4010); set_cnt(16'd0);
    acc(1, 16'hEEEE, rd, lat);
    chk("R7 rdy latency", lat, 1);
    chk("R7 addr held", cur_addr, 16'h4010); chk("R7 cnt held", remain, 0);
    chk("R7 no done", dma_done, 0);
    set_cnt(16'd1);
    acc(0, 0, rd, lat);
    chk("R7 mem untouched", rd, {8'h00, wpat(8) & 16'h00FF});

    // R6 count below word step
    clr_done();
    wr_reg(4'd7, 8'h01);
    set_addr(16'h4020); set_cnt(16'd1);
    acc(1, 16'hBEEF, rd, lat);
    chk("R6 short cnt", remain, 0); chk("R6 short done", dma_done, 1);
    chk("R6 short addr", cur_addr, 16'h4022);

    // R8 command with zero count
    clr_done(); wr_reg(4'd0, 8'h08); chk("R8 rd cmd", dma_done, 1);
    clr_done(); wr_reg(4'd0, 8'h10); chk("R8 wr cmd", dma_done, 1);
    clr_done(); wr_reg(4'd0, 8'h09); chk("R8 stop cmd", dma_done, 0);
    wr_reg(4'd0, 8'h20); chk("R8 no dir", dma_done, 0);
    set_cnt(16'd5); wr_reg(4'd0, 8'h08); chk("R8 nonzero cnt", dma_done, 0);

    // R9 window edges
    wr_reg(4'd7, 8'h00);
    set_addr(16'h0020); set_cnt(16'd8);
    acc(1, 16'h0077, rd, lat);
    set_addr(16'h0020); acc(0, 0, rd, lat);
    chk("R9 above low win", rd, 16'h00FF);
    set_addr(16'h3FFF); acc(0, 0, rd, lat);
    chk("R9 below high win", rd, 16'h00FF);
    set_addr(16'h47FF); acc(1, 16'h0033, rd, lat);
    set_addr(16'h47FF); acc(0, 0, rd, lat);
    chk("R9 last backed", rd, 16'h0033);
    set_addr(16'h4800); acc(1, 16'h0044, rd, lat);
    set_addr(16'h4800); acc(0, 0, rd, lat);
    chk("R9 past high win", rd, 16'h00FF);
    set_cnt(16'd4);
    set_addr(16'h0000); acc(0, 0, rd, lat);
    chk("R9 no alias low", rd, {8'h00, bpat(0)});
    set_addr(16'h001F); acc(0, 0, rd, lat);
    chk("R9 last low", rd, {8'h00, bpat(31)});
    wr_reg(4'd7, 8'h01);
    set_addr(16'h3FFE); set_cnt(16'd2); acc(0, 0, rd, lat);
    chk("R9 word unbacked", rd, 16'hFFFF);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule